// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in and returns the sum and a carry-out. It contains no carry ripple chain of any length. Every carry comes from a tree of identical lookahead cells. Each cell accepts four propagate/generate pairs and one carry-in. From these it forms the three carries inside its span, the carry leaving its span, and a combined propagate/generate pair that it passes to the level above.

At the bottom, each operand bit produces a generate term (the AND of the two bits) and a propagate term (the inclusive OR of the two bits). One row of cells groups these bit terms four at a time. Each further row groups the pairs from the row below four at a time. The single cell at the root receives the external carry-in. Carries then flow back down the tree, and each cell hands the carry-in of every one of its four children to that child. The carry-out that a lower cell computes is redundant, because its neighbour already receives that carry from the cell above.

The number of tree levels is a parameter, and the operand width is four to the power of that count. The default of three levels gives a 64-bit adder. Two levels give a 16-bit adder. The path is purely combinational and holds no state.

Top module: `cla_adder_tree`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals a + b + cin computed at WIDTH+1 bits.
- R2: When operand bit k is 1 in both operands and every other bit and cin are 0, sum has only bit k+1 set, or cout is 1 with sum zero when k is the top bit.
- R3: A carry propagates across a bit where exactly one operand bit is 1. With a all ones, b zero and cin 1, sum is zero and cout is 1.
- R4: A carry leaving a 4-bit group reaches the next group. With a = 0xF, b = 0 and cin = 1, sum = 0x10.
- R5: A carry leaving a 16-bit span reaches the next span through the upper tree level. With a = 0xFFFF, b = 0 and cin = 1 on the 64-bit adder, sum = 0x10000.
- R6: cout is the span carry of the root cell. With both operands all ones and cin 1, sum is all ones and cout is 1.
- R7: The same structure computes correct results at 1, 2 and 3 levels (4, 16 and 64 bits).
- R8: With zero operands and cin 0, sum and cout are 0.
- R9: The span carry of every cell equals the carry-in that the tree delivers to the neighbouring span above it. A cell whose combined generate is 1 always produces a span carry.
- R10: With zero operands and cin 1, sum is 1 and cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand (WIDTH = 4**LEVELS) |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
There is no register between any input and any output, so each result belongs to the operands applied in the same cycle. The bench drives a new vector just after a rising edge and compares sum and cout at the following falling edge. By then the tree has settled, and no other vector is in flight. Three instances at 1, 2 and 3 levels receive the same stimulus. The 4-bit instance is swept exhaustively. The wider instances get pseudo-random vectors and carry chains that cross group and span boundaries.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Outputs of one lookahead cell
    typedef struct packed {
        logic [4:1] c;     // carries into positions 1..3, and the span carry (4)
        logic       gout;  // combined generate
        logic       pout;  // combined propagate
    } cla_cell_out_t;

    // Index of the first node of tree level lvl in the flattened node vector.
    // Level 0 holds one node per bit, level k holds width / 4**k nodes.
    function automatic int cla_level_base(input int width, input int lvl);
        int acc;
        acc = 0;
        for (int k = 0; k < lvl; k++) begin
            acc += width >> (2 * k);
        end
        return acc;
    endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] p,
    output logic [WIDTH-1:0] g,
    output logic [WIDTH-1:0] x
);

    // Per bit: generate, inclusive-OR propagate, and the half sum used by the sum stage
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            g[i] = a[i] & b[i];
            p[i] = a[i] | b[i];
            x[i] = a[i] ^ b[i];
        end
    end

endmodule

// File: rtl/cla_cell.sv
module cla_cell
    import cla_pkg::*;
(
    input  logic [3:0] p,
    input  logic [3:0] g,
    input  logic       ci,
    output logic [4:1] c,
    output logic       gout,
    output logic       pout
);

    cla_cell_out_t res_d;

    // Fully expanded two-level lookahead: no carry depends on another carry
    always_comb begin
        res_d.c[1] = g[0] | (p[0] & ci);
        res_d.c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
        res_d.c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                   | (p[2] & p[1] & p[0] & ci);
        res_d.c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                   | (p[3] & p[2] & p[1] & g[0])
                   | (p[3] & p[2] & p[1] & p[0] & ci);
        res_d.gout = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                   | (p[3] & p[2] & p[1] & g[0]);
        res_d.pout = &p;
    end

    assign c    = res_d.c;
    assign gout = res_d.gout;
    assign pout = res_d.pout;

    // A combined generate always produces the span carry
    always_comb begin
        if (gout) assert_gen_carries_R9: assert (c[4]);
    end

    // Full propagate passes the carry-in through to the span carry
    always_comb begin
        if (pout) assert_prop_passes_R3: assert (c[4] == (ci | gout));
    end

    // Neither generate nor propagate: no span carry
    always_comb begin
        if (!gout && !pout && !ci) assert_no_source_R8: assert (!c[4]);
    end

endmodule

// File: rtl/cla_adder_tree.sv
module cla_adder_tree
    import cla_pkg::*;
#(
    parameter int LEVELS = 3,
    localparam int WIDTH = 4 ** LEVELS
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int NODES = cla_level_base(WIDTH, LEVELS + 1);
    localparam int CELLS = NODES - WIDTH;

    logic [NODES-1:0] p_n;    // propagate per tree node, level by level
    logic [NODES-1:0] g_n;    // generate per tree node
    logic [NODES-1:0] c_n;    // carry into each tree node
    logic [CELLS-1:0] c4_w;   // span carry of every cell
    logic [WIDTH-1:0] hsum;

    cla_bit_pg #(.WIDTH(WIDTH)) u_pg (
        .a (a),
        .b (b),
        .p (p_n[WIDTH-1:0]),
        .g (g_n[WIDTH-1:0]),
        .x (hsum)
    );

    // The root node takes the external carry
    assign c_n[NODES-1] = cin;

    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
        localparam int LO  = cla_level_base(WIDTH, lv - 1);
        localparam int HI  = cla_level_base(WIDTH, lv);
        localparam int CNT = WIDTH >> (2 * lv);
        for (genvar j = 0; j < CNT; j++) begin : g_cell
            cla_cell u_cell (
                .p    (p_n[LO + 4*j +: 4]),
                .g    (g_n[LO + 4*j +: 4]),
                .ci   (c_n[HI + j]),
                .c    ({c4_w[HI - WIDTH + j], c_n[LO + 4*j + 1 +: 3]}),
                .gout (g_n[HI + j]),
                .pout (p_n[HI + j])
            );
            // First child inherits the parent's carry-in
            assign c_n[LO + 4*j] = c_n[HI + j];

            // Span carry matches the carry delivered to the next span above it
            if (j + 1 < CNT) begin : g_chk_mid
                always_comb begin
                    assert_span_chain_R9: assert (c4_w[HI - WIDTH + j] == c_n[HI + j + 1]);
                end
            end else if (lv < LEVELS) begin : g_chk_last
                localparam int UP = cla_level_base(WIDTH, lv + 1);
                always_comb begin
                    assert_span_parent_R9: assert (c4_w[HI - WIDTH + j] == c4_w[UP - WIDTH + j/4]);
                end
            end
        end
    end

    assign sum  = hsum ^ c_n[WIDTH-1:0];
    assign cout = c4_w[CELLS-1];

    // Root carry-out follows the root's combined terms
    always_comb begin
        assert_root_cout_R6: assert (cout == (g_n[NODES-1] | (p_n[NODES-1] & cin)));
    end

    // Arithmetic result
    always_comb begin
        assert_sum_value_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    end

endmodule

// File: tb/tb_cla_adder_tree.sv
module tb_cla_adder_tree;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [63:0] a_r = '0;
    logic [63:0] b_r = '0;
    logic        ci_r = 1'b0;

    logic [63:0] s64;  logic co64;
    logic [15:0] s16;  logic co16;
    logic [3:0]  s4;   logic co4;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    cla_adder_tree #(.LEVELS(3)) dut (
        .a(a_r), .b(b_r), .cin(ci_r), .sum(s64), .cout(co64));
    cla_adder_tree #(.LEVELS(2)) dut_l2 (
        .a(a_r[15:0]), .b(b_r[15:0]), .cin(ci_r), .sum(s16), .cout(co16));
    cla_adder_tree #(.LEVELS(1)) dut_l1 (
        .a(a_r[3:0]), .b(b_r[3:0]), .cin(ci_r), .sum(s4), .cout(co4));

    task automatic chk(input string rq, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Apply one vector to all widths, check on the falling edge
    task automatic apply(input string rq, input logic [63:0] av, input logic [63:0] bv,
                         input logic cv);
        logic [64:0] e64;
        logic [16:0] e16;
        logic [4:0]  e4;
        @(posedge clk); #1;
        a_r = av; b_r = bv; ci_r = cv;
        e64 = {1'b0, av} + {1'b0, bv} + {64'd0, cv};
        e16 = {1'b0, av[15:0]} + {1'b0, bv[15:0]} + {16'd0, cv};
        e4  = {1'b0, av[3:0]} + {1'b0, bv[3:0]} + {4'd0, cv};
        @(negedge clk);
        chk({rq, "/64"}, {co64, s64}, e64);
        chk({rq, "/16"}, {48'd0, co16, s16}, {48'd0, e16});
        chk({rq, "/4"},  {60'd0, co4, s4},   {60'd0, e4});
    endtask

    initial begin
        // R8: quiet inputs during reset give zero outputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset", {co64, s64}, 65'd0);
        rst_n = 1'b1;

        apply("R8", 64'd0, 64'd0, 1'b0);
        apply("R10", 64'd0, 64'd0, 1'b1);
        @(negedge clk);
        chk("R10 direct", {co64, s64}, 65'd1);

        // R2: single generate at every bit position
        for (int k = 0; k < 64; k++) begin
            apply("R2", 64'd1 << k, 64'd1 << k, 1'b0);
            @(negedge clk);
            chk("R2 direct", {co64, s64}, 65'd1 << (k + 1));
        end

        // R3: full propagate chain, with the ones split between operands
        apply("R3", '1, 64'd0, 1'b1);
        @(negedge clk);
        chk("R3 direct", {co64, s64}, {1'b1, 64'd0});
        apply("R3", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);

        // R4 / R5: group and span boundary crossings
        apply("R4", 64'hF, 64'd0, 1'b1);
        @(negedge clk);
        chk("R4 direct", {co64, s64}, 65'h10);
        apply("R5", 64'hFFFF, 64'd0, 1'b1);
        @(negedge clk);
        chk("R5 direct", {co64, s64}, 65'h1_0000);
        apply("R5", 64'hFFFF_FFFF_FFFF, 64'd1, 1'b0);

        // R9: carry produced in one span lands in each span above it
        for (int k = 0; k < 16; k++) begin
            apply("R9", (64'd1 << (4*k + 3)) | ((64'd1 << (4*k + 3)) - 1), 64'd1 << (4*k + 3), 1'b0);
        end

        // R6: all ones plus all ones plus carry
        apply("R6", '1, '1, 1'b1);
        @(negedge clk);
        chk("R6 direct", {co64, s64}, {1'b1, {64{1'b1}}});

        // R7 / R1: exhaustive over the 4-bit instance
        for (int v = 0; v < 512; v++) begin
            apply("R7", {60'd0, v[3:0]}, {60'd0, v[7:4]}, v[8]);
        end

        // R1: pseudo-random vectors across all widths
        for (int v = 0; v < 6000; v++) begin
            apply("R1", {$urandom, $urandom}, {$urandom, $urandom}, v[0]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule